// File: doc/BRIEF.md
# Per-Unit Issue Queue with Tag Wakeup and Hazard Gate

This block holds instructions that have been dispatched to one execution unit and are waiting for their source operands. Each of its four slots keeps two source physical-register tags with a ready flag for each, the destination physical tag and the reorder-buffer index of the instruction. A result broadcast on the writeback tag bus sets the ready flag of every waiting source whose tag matches. Once both flags of a slot are set, the slot can leave the queue on the following clock cycle.

Every execution unit has its own copy of this queue. Issue is also gated by a busy signal from the scoreboard. When that signal is high, the operation cannot start without a structural or data hazard, so nothing leaves the queue. When several slots can issue, the one dispatched earliest wins. An age matrix tracks that order, so slot position has no effect on priority. A full flag stalls dispatch, and a flush empties the queue.

Top module: `issue_queue`

## Requirements
- R1: While `rst` is high on a clock edge, every slot becomes empty. After reset `full` and `iss_valid` are low until something is inserted.
- R2: With `disp_valid` high, `full` low and `flush` low, the instruction is written at the clock edge into the lowest-numbered empty slot. When it later issues, `iss_dst_tag` and `iss_rob_idx` return the values it was inserted with.
- R3: A source enters its slot ready if its `disp_srcN_rdy` flag is high. It also enters ready if `wb_valid` is high in the same cycle with `wb_tag` equal to that source's tag.
- R4: A writeback broadcast (`wb_valid` high) sets, at the clock edge, the ready flag of every source in every occupied slot whose tag equals `wb_tag`. A slot whose second flag is set this way can issue in the next cycle.
- R5: `iss_valid` is high in a cycle exactly when some occupied slot has both ready flags set, `sb_busy` is low and `flush` is low. The issued slot becomes empty at that clock edge. While `sb_busy` is high, ready slots stay in the queue.
- R6: Among issue-ready slots, the one inserted earliest is selected, whatever its slot number. `iss_slot` gives its index (0 to 3).
- R7: `full` is high exactly when all four slots are occupied. A dispatch offered while `full` is high is dropped, even in a cycle in which a slot issues.
- R8: With `flush` high, no slot issues and no dispatch is accepted in that cycle, and every slot is empty after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all queued instructions |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_src0_tag | input | 6 | First source physical tag |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1_tag | input | 6 | Second source physical tag |
| disp_src1_rdy | input | 1 | Second source already available |
| disp_dst_tag | input | 6 | Destination physical tag |
| disp_rob_idx | input | 5 | Reorder-buffer index |
| wb_valid | input | 1 | Writeback broadcast valid |
| wb_tag | input | 6 | Tag of the result being written back |
| sb_busy | input | 1 | Scoreboard reports a hazard for this unit |
| full | output | 1 | All slots occupied; dispatch must stall |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_slot | output | 2 | Slot index of the issued instruction |
| iss_dst_tag | output | 6 | Destination tag of the issued instruction |
| iss_rob_idx | output | 5 | Reorder-buffer index of the issued instruction |

## Verification
The bench aims at the cases that break a naive queue. It broadcasts a tag in the same cycle the instruction needing it is inserted; a queue without that bypass would hold the instruction forever. It refills a low-numbered slot with the youngest instruction and then wakes everything at once; lowest-index selection would issue that newcomer before older work. It also holds `sb_busy` high over ready slots, which a queue that ignored the scoreboard would issue and lose. It offers a dispatch while the queue is full and a slot is issuing, where an off-by-one full check would overwrite a live slot. Finally it flushes in a cycle that also carries a dispatch, which must not leave a stray entry behind.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int IQ_DEPTH = 4;
    localparam int TAG_W    = 6;
    localparam int ROB_W    = 5;
    localparam int SLOT_W   = (IQ_DEPTH > 1) ? $clog2(IQ_DEPTH) : 1;

    typedef logic [TAG_W-1:0]  ptag_t;
    typedef logic [ROB_W-1:0]  rob_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic  vld;
        ptag_t src0_tag;
        logic  src0_rdy;
        ptag_t src1_tag;
        logic  src1_rdy;
        ptag_t dst_tag;
        rob_t  rob_idx;
    } iq_ent_t;

    // True when a live broadcast carries the given source tag.
    function automatic logic tag_hit(input logic bc_vld, input ptag_t bc_tag,
                                     input ptag_t src);
        return bc_vld && (bc_tag == src);
    endfunction

    // Index of the lowest empty slot (0 when none is empty).
    function automatic slot_t lowest_clear(input logic [IQ_DEPTH-1:0] v);
        slot_t r;
        r = '0;
        for (int i = IQ_DEPTH - 1; i >= 0; i--) begin
            if (!v[i]) r = slot_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/iq_slot.sv
module iq_slot
    import iq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  logic    wr_en,
    input  iq_ent_t wr_ent,
    input  logic    clr,
    input  logic    wb_valid,
    input  ptag_t   wb_tag,
    output iq_ent_t ent_q,
    output logic    elig
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ent_q <= '0;
        end else if (wr_en) begin
            ent_q <= wr_ent;
        end else begin
            if (clr) ent_q.vld <= 1'b0;
            if (tag_hit(wb_valid, wb_tag, ent_q.src0_tag)) ent_q.src0_rdy <= 1'b1;
            if (tag_hit(wb_valid, wb_tag, ent_q.src1_tag)) ent_q.src1_rdy <= 1'b1;
        end
    end

    assign elig = ent_q.vld && ent_q.src0_rdy && ent_q.src1_rdy;
endmodule

// File: rtl/iq_age_matrix.sv
module iq_age_matrix #(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                ins_en,
    input  logic [N-1:0]        ins_onehot,
    input  logic [N-1:0]        valid_vec,
    // older[i][j] set: slot j holds an instruction older than slot i
    output logic [N-1:0][N-1:0] older
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            older <= '0;
        end else if (ins_en) begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (ins_onehot[i])
                        older[i][j] <= valid_vec[j] && (i != j);
                    else if (ins_onehot[j])
                        older[i][j] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/iq_oldest_pick.sv
module iq_oldest_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]        elig,
    input  logic [N-1:0][N-1:0] older,
    output logic [N-1:0]        grant,
    output logic [IW-1:0]       idx,
    output logic                any
);
    for (genvar g = 0; g < N; g++) begin : g_gnt
        assign grant[g] = elig[g] && ((older[g] & elig) == '0);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    assign any = |elig;
endmodule

// File: rtl/issue_queue.sv
module issue_queue
    import iq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             disp_valid,
    input  logic [TAG_W-1:0] disp_src0_tag,
    input  logic             disp_src0_rdy,
    input  logic [TAG_W-1:0] disp_src1_tag,
    input  logic             disp_src1_rdy,
    input  logic [TAG_W-1:0] disp_dst_tag,
    input  logic [ROB_W-1:0] disp_rob_idx,
    input  logic             wb_valid,
    input  logic [TAG_W-1:0] wb_tag,
    input  logic             sb_busy,
    output logic             full,
    output logic             iss_valid,
    output logic [SLOT_W-1:0] iss_slot,
    output logic [TAG_W-1:0] iss_dst_tag,
    output logic [ROB_W-1:0] iss_rob_idx
);
    iq_ent_t                          ents [IQ_DEPTH];
    logic [IQ_DEPTH-1:0]              valid_vec;
    logic [IQ_DEPTH-1:0]              elig_vec;
    logic [IQ_DEPTH-1:0]              grant;
    logic [IQ_DEPTH-1:0]              ins_onehot;
    logic [IQ_DEPTH-1:0][IQ_DEPTH-1:0] older;
    logic                             accept;
    slot_t                            ins_slot;
    slot_t                            pick_idx;
    logic                             pick_any;
    iq_ent_t                          new_ent;

    assign full     = &valid_vec;
    assign accept   = disp_valid && !full && !flush;
    assign ins_slot = lowest_clear(valid_vec);

    always_comb begin
        new_ent          = '0;
        new_ent.vld      = 1'b1;
        new_ent.src0_tag = disp_src0_tag;
        new_ent.src0_rdy = disp_src0_rdy || tag_hit(wb_valid, wb_tag, disp_src0_tag);
        new_ent.src1_tag = disp_src1_tag;
        new_ent.src1_rdy = disp_src1_rdy || tag_hit(wb_valid, wb_tag, disp_src1_tag);
        new_ent.dst_tag  = disp_dst_tag;
        new_ent.rob_idx  = disp_rob_idx;
    end

    for (genvar g = 0; g < IQ_DEPTH; g++) begin : g_slot
        assign ins_onehot[g] = accept && (ins_slot == slot_t'(g));
        assign valid_vec[g]  = ents[g].vld;

        iq_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .wr_en    (ins_onehot[g]),
            .wr_ent   (new_ent),
            .clr      (iss_valid && grant[g]),
            .wb_valid (wb_valid),
            .wb_tag   (wb_tag),
            .ent_q    (ents[g]),
            .elig     (elig_vec[g])
        );
    end

    iq_age_matrix #(.N(IQ_DEPTH)) u_age (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .ins_en     (accept),
        .ins_onehot (ins_onehot),
        .valid_vec  (valid_vec),
        .older      (older)
    );

    iq_oldest_pick #(.N(IQ_DEPTH), .IW(SLOT_W)) u_pick (
        .elig  (elig_vec),
        .older (older),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    assign iss_valid   = pick_any && !sb_busy && !flush;
    assign iss_slot    = pick_idx;
    assign iss_dst_tag = ents[pick_idx].dst_tag;
    assign iss_rob_idx = ents[pick_idx].rob_idx;
endmodule

// File: rtl/iq_chk.sv
module iq_chk
    import iq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                flush,
    input logic                sb_busy,
    input logic                full,
    input logic                iss_valid,
    input logic [SLOT_W-1:0]   iss_slot,
    input logic [IQ_DEPTH-1:0] valid_vec
);
    // R1
    reset_empties_chk: assert property (@(posedge clk) rst |=> (valid_vec == '0));

    // R5
    busy_blocks_issue_chk: assert property (@(posedge clk) disable iff (rst)
        sb_busy |-> !iss_valid);

    // R5
    issued_slot_freed_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> !valid_vec[$past(iss_slot)]);

    // R2
    issue_from_occupied_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> valid_vec[iss_slot]);

    // R7
    full_drops_insert_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !iss_valid && !flush) |=> $stable(valid_vec));

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0 && !full));

    // R8
    flush_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> !iss_valid);
endmodule

bind issue_queue iq_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .sb_busy   (sb_busy),
    .full      (full),
    .iss_valid (iss_valid),
    .iss_slot  (iss_slot),
    .valid_vec (valid_vec)
);

// File: tb/issue_queue_tb_top.sv
module issue_queue_tb_top;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       disp_valid = 1'b0;
    logic [5:0] disp_src0_tag = '0;
    logic       disp_src0_rdy = 1'b0;
    logic [5:0] disp_src1_tag = '0;
    logic       disp_src1_rdy = 1'b0;
    logic [5:0] disp_dst_tag = '0;
    logic [4:0] disp_rob_idx = '0;
    logic       wb_valid = 1'b0;
    logic [5:0] wb_tag = '0;
    logic       sb_busy = 1'b0;
    logic       full;
    logic       iss_valid;
    logic [1:0] iss_slot;
    logic [5:0] iss_dst_tag;
    logic [4:0] iss_rob_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    bit m_v[D];
    int m_s0[D], m_s1[D], m_d[D], m_rb[D], m_seq[D];
    bit m_r0[D], m_r1[D];
    int seq_ctr = 0;

    always #2 clk = ~clk;

    issue_queue dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .disp_valid(disp_valid),
        .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
        .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy),
        .disp_dst_tag(disp_dst_tag), .disp_rob_idx(disp_rob_idx),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .sb_busy(sb_busy),
        .full(full), .iss_valid(iss_valid), .iss_slot(iss_slot),
        .iss_dst_tag(iss_dst_tag), .iss_rob_idx(iss_rob_idx)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < D; i++) begin
            m_v[i] = 0; m_r0[i] = 0; m_r1[i] = 0;
        end
    endtask

    // Compare outputs against the reference, then advance the reference one edge.
    task automatic model_cycle();
        bit e_full;
        int best;
        int free;
        bit e_iv;
        e_full = 1;
        best = -1;
        for (int i = 0; i < D; i++) begin
            if (!m_v[i]) e_full = 0;
            if (m_v[i] && m_r0[i] && m_r1[i] && (best < 0 || m_seq[i] < m_seq[best]))
                best = i;
        end
        e_iv = (best >= 0) && !sb_busy && !flush;
        chk("R7", "full", int'(full), int'(e_full));
        chk("R3 R4 R5 R8", "iss_valid", int'(iss_valid), int'(e_iv));
        if (e_iv && iss_valid) begin
            chk("R6", "iss_slot", int'(iss_slot), best);
            chk("R2", "iss_dst_tag", int'(iss_dst_tag), m_d[best]);
            chk("R2", "iss_rob_idx", int'(iss_rob_idx), m_rb[best]);
        end
        if (flush) begin
            model_clear();
        end else begin
            free = -1;
            for (int i = 0; i < D; i++) if (!m_v[i] && free < 0) free = i;
            for (int i = 0; i < D; i++) begin
                if (m_v[i] && wb_valid && m_s0[i] == int'(wb_tag)) m_r0[i] = 1;
                if (m_v[i] && wb_valid && m_s1[i] == int'(wb_tag)) m_r1[i] = 1;
            end
            if (e_iv) m_v[best] = 0;
            if (disp_valid && !e_full) begin
                m_v[free]   = 1;
                m_s0[free]  = int'(disp_src0_tag);
                m_s1[free]  = int'(disp_src1_tag);
                m_r0[free]  = disp_src0_rdy || (wb_valid && wb_tag == disp_src0_tag);
                m_r1[free]  = disp_src1_rdy || (wb_valid && wb_tag == disp_src1_tag);
                m_d[free]   = int'(disp_dst_tag);
                m_rb[free]  = int'(disp_rob_idx);
                m_seq[free] = seq_ctr;
                seq_ctr++;
            end
        end
    endtask

    task automatic cyc(input bit dv, input int s0, input bit r0, input int s1, input bit r1,
                       input int d, input int rb, input bit wv, input int wt,
                       input bit bz, input bit fl);
        @(negedge clk);
        disp_valid = dv; disp_src0_tag = 6'(s0); disp_src0_rdy = r0;
        disp_src1_tag = 6'(s1); disp_src1_rdy = r1;
        disp_dst_tag = 6'(d); disp_rob_idx = 5'(rb);
        wb_valid = wv; wb_tag = 6'(wt); sb_busy = bz; flush = fl;
        #1;
        model_cycle();
    endtask

    task automatic idle(input bit bz);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, bz, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk("R1", "full after reset", int'(full), 0);
        chk("R1", "iss_valid after reset", int'(iss_valid), 0);

        // R3: tag broadcast in the insert cycle counts
        cyc(1, 5, 0, 6, 0, 33, 1, 1, 5, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 6, 0, 0);
        idle(0);
        idle(0);

        // R6/R7: fill, drop while full, refill low slot with youngest
        for (int i = 0; i < D; i++) cyc(1, 10 + i, 0, 30, 0, 40 + i, 10 + i, 0, 0, 0, 0);
        cyc(1, 1, 1, 1, 1, 50, 9, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 30, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 11, 0, 0);
        cyc(1, 2, 1, 2, 1, 51, 8, 0, 0, 0, 0);   // slot 1 issues; dispatch dropped (full)
        cyc(1, 3, 1, 4, 1, 45, 5, 0, 0, 1, 0);   // youngest into slot 1, busy
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 10, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 12, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 13, 1, 0);
        idle(1);
        repeat (5) idle(0);                       // drain order 0,2,3,1

        // R8: flush with a dispatch in the same cycle
        cyc(1, 1, 1, 2, 1, 20, 2, 0, 0, 1, 0);
        cyc(1, 1, 1, 2, 1, 21, 3, 0, 0, 1, 0);
        cyc(1, 7, 1, 7, 1, 22, 4, 0, 0, 0, 1);
        idle(0);
        idle(0);

        // random traffic over a small tag space
        for (int n = 0; n < 4000; n++) begin
            cyc($urandom_range(9) < 6, $urandom_range(7), $urandom_range(3) == 0,
                $urandom_range(7), $urandom_range(3) == 0,
                $urandom_range(63), $urandom_range(31),
                $urandom_range(1) == 1, $urandom_range(7),
                $urandom_range(3) == 0, $urandom_range(49) == 0);
        end
        repeat (6) idle(0);
        finish_run();
    end
endmodule